// File: doc/BRIEF.md
# Bit-Serial Lightweight Feistel Block Cipher Engine

This engine encrypts one block with the lightweight AND-rotate-XOR Feistel cipher, and it computes a single bit of the cipher state on each clock. Storage is built only from shift registers. The two halves of the block are held in two serial word queues. The key words are held in one long serial chain.

Each queue is made from 16-bit subsections. A gating multiplexer at the input of each subsection either passes the chained bit or forces zero. The word size and the number of key words decide which subsections are active.

The upper half recirculates through its own register, so its rotated copies are read from fixed taps. A round therefore costs one cycle per bit of the word. The plaintext and key are loaded in parallel when a start strobe is accepted. The ciphertext is read in parallel after the done pulse.

Three configurations are selected by a 2-bit code:

| Code | Block / key bits | Word size n | Key words m | Rounds |
|---|---|---|---|---|
| 0 | 32 / 64 | 16 | 4 | 32 |
| 1 | 64 / 96 | 32 | 3 | 42 |
| 2 | 64 / 128 | 32 | 4 | 44 |

Code 3 is unused.

Top module: `simon_serial_core`

## Requirements
- R1: With code 0, {ct_hi[15:0], ct_lo[15:0]} equals the 32/64 encryption of upper word pt_hi[15:0] and lower word pt_lo[15:0]. The key word j is key[16j+15:16j], with word 0 used by the first round. For example, key 64'h1918111009080100 with plaintext 6565/6877 gives c69b/e9bb.
- R2: With code 1, the outputs equal the 64/96 encryption, where key word j is key[32j+31:32j] for j = 0..2. For example, key 96'h13121110_0b0a0908_03020100 with plaintext 6f722067/6e696c63 gives 5ca2e27f/111a8fc8.
- R3: With code 2, the outputs equal the 64/128 encryption, where key word j is key[32j+31:32j] for j = 0..3. For example, key 128'h1b1a1918_13121110_0b0a0908_03020100 with plaintext 656b696c/20646e75 gives 44c8fc20/b9dfa07a.
- R4: start is accepted on a rising edge while busy is low and the code is not 3. busy is high from the next cycle onward. done rises exactly rounds × n edges after the accepting edge, together with busy falling. done lasts one cycle.
- R5: A start while busy is high is ignored: the running encryption's result and its length are unchanged.
- R6: A start with code 3 is ignored: busy stays low, done stays low and the ciphertext outputs keep their values.
- R7: With code 0, bits 31:16 of both ciphertext outputs read zero. pt bits above 15 and key bits above 63 have no effect. With code 1, key bits above 95 have no effect.
- R8: After reset, busy, done, ct_hi and ct_lo are all zero.
- R9: While idle, the ciphertext outputs hold their value whatever the pt and key inputs do, until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled on the rising edge |
| cfg | input | 2 | Configuration code (0: 32/64, 1: 64/96, 2: 64/128, 3: unused) |
| pt_hi | input | 32 | Upper plaintext word, low n bits used |
| pt_lo | input | 32 | Lower plaintext word, low n bits used |
| key | input | 128 | Key words packed with word 0 in the least significant bits |
| busy | output | 1 | High while rounds are being computed |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| ct_hi | output | 32 | Upper ciphertext word |
| ct_lo | output | 32 | Lower ciphertext word |

## Verification
Every state bit feeds forward through dozens of rounds, so one wrong tap, mask or constant bit garbles the whole ciphertext. That damage is seen at the single done pulse of each encryption. A wrong subsection gate or a misplaced wrap point in the key chain often shows up only in one configuration, which is why all three codes are run with random and known-answer data. A miscounted bit or round counter moves the done pulse away from rounds × n edges, and the cycle count of every run catches that at once.

// File: rtl/simon_ser_pkg.sv
package simon_ser_pkg;

    typedef enum logic [1:0] {
        CFG_32_64  = 2'd0,
        CFG_64_96  = 2'd1,
        CFG_64_128 = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_e;

    localparam int SECT_W     = 16;
    localparam int WMAX       = 32;
    localparam int KMAX       = 128;
    localparam int DATA_SECTS = WMAX / SECT_W;
    localparam int KEY_SECTS  = KMAX / SECT_W;
    localparam int MAX_ROUNDS = 44;
    localparam int BIT_W      = $clog2(WMAX);
    localparam int RND_W      = $clog2(MAX_ROUNDS);
    localparam int KIDX_W     = $clog2(KMAX);
    localparam int RUN_W      = $clog2(MAX_ROUNDS * WMAX + 1);
    localparam int ZLEN       = 62;

    // Round constant sequences, first round at the most significant bit
    localparam logic [ZLEN-1:0] ZSEQ_A = 62'b11111010001001010110000111001101111101000100101011000011100110;
    localparam logic [ZLEN-1:0] ZSEQ_C = 62'b10101111011100000011010010011000101000010001111110010110110011;
    localparam logic [ZLEN-1:0] ZSEQ_D = 62'b11011011101011000110010111100000010010001010011100110100001111;

    function automatic int word_bits(cfg_e c);
        return (c == CFG_32_64) ? 16 : 32;
    endfunction

    function automatic int key_words(cfg_e c);
        return (c == CFG_64_96) ? 3 : 4;
    endfunction

    function automatic int round_total(cfg_e c);
        case (c)
            CFG_32_64:  return 32;
            CFG_64_96:  return 42;
            CFG_64_128: return 44;
            default:    return 0;
        endcase
    endfunction

    function automatic logic z_bit(cfg_e c, logic [RND_W-1:0] r);
        logic [ZLEN-1:0] zz;
        int idx;
        idx = int'(r) % ZLEN;
        case (c)
            CFG_32_64: zz = ZSEQ_A;
            CFG_64_96: zz = ZSEQ_C;
            default:   zz = ZSEQ_D;
        endcase
        return zz[6'(ZLEN - 1 - idx)];
    endfunction

    function automatic logic [DATA_SECTS-1:0] data_mask(cfg_e c);
        return (c == CFG_32_64) ? DATA_SECTS'(1) : {DATA_SECTS{1'b1}};
    endfunction

    function automatic logic [KEY_SECTS-1:0] key_mask(cfg_e c);
        int act;
        act = (key_words(c) * word_bits(c)) / SECT_W;
        return KEY_SECTS'((1 << act) - 1);
    endfunction

    // Word after one serial step with a bit pushed in at the top of the active width
    function automatic logic [WMAX-1:0] push_top(logic [WMAX-1:0] w, logic b, logic wide);
        return wide ? {b, w[WMAX-1:1]} : {16'h0, b, w[15:1]};
    endfunction

endpackage

// File: rtl/bitser_fifo.sv
module bitser_fifo
    import simon_ser_pkg::*;
#(
    parameter int SW = 16,
    parameter int NS = 2,
    localparam int W = SW * NS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] act,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          shift,
    input  logic          ser_in,
    output logic [W-1:0]  q
);

    logic [W-1:0]  r;
    logic [W-1:0]  nxt;
    logic [W-1:0]  keep;
    logic [NS-1:0] sect_in;

    for (genvar s = 0; s < NS; s++) begin : g_sect
        logic link;
        if (s == NS - 1) begin : g_top
            assign link = ser_in;
        end else begin : g_chain
            // the highest active subsection takes the serial input
            assign link = act[s+1] ? r[(s+1)*SW] : ser_in;
        end
        // input gate: pass the chained bit, or tie it low when disabled
        assign sect_in[s]          = act[s] ? link : 1'b0;
        assign nxt[s*SW +: SW]     = {sect_in[s], r[s*SW+1 +: SW-1]};
        assign keep[s*SW +: SW]    = {SW{act[s]}};
    end

    always_ff @(posedge clk) begin
        if (rst)        r <= '0;
        else if (load)  r <= load_val & keep;
        else if (shift) r <= nxt;
    end

    assign q = r;

endmodule

// File: rtl/simon_ser_ctrl.sv
module simon_ser_ctrl
    import simon_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cfg_e             cfg_in,
    output logic             busy,
    output logic             done,
    output logic             go,
    output logic             last_bit,
    output cfg_e             cfg_q,
    output logic [BIT_W-1:0] bit_idx,
    output logic [RND_W-1:0] rnd
);

    logic last_rnd;

    assign go       = start & ~busy & (cfg_in != CFG_NONE);
    assign last_bit = (bit_idx == BIT_W'(word_bits(cfg_q) - 1));
    assign last_rnd = (rnd == RND_W'(round_total(cfg_q) - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            bit_idx <= '0;
            rnd     <= '0;
            cfg_q   <= CFG_32_64;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy    <= 1'b1;
                bit_idx <= '0;
                rnd     <= '0;
                cfg_q   <= cfg_in;
            end else if (busy) begin
                if (last_bit) begin
                    bit_idx <= '0;
                    if (last_rnd) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        rnd <= rnd + 1'b1;
                    end
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/simon_ser_keysched.sv
module simon_ser_keysched
    import simon_ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cfg_e                 cfg,
    input  logic [KEY_SECTS-1:0] act,
    input  logic                 load,
    input  logic [KMAX-1:0]      key_in,
    input  logic                 step,
    input  logic [BIT_W-1:0]     bit_idx,
    input  logic                 zc,
    output logic                 kbit
);

    logic [KMAX-1:0]   ch;
    logic [KIDX_W-1:0] i3, i4, j0, j1;
    logic              a3, a4, b0, b1, cst, fresh;
    int                nn, mm, top_base, prev_base, bi;

    always_comb begin
        nn        = word_bits(cfg);
        mm        = key_words(cfg);
        bi        = int'(bit_idx);
        top_base  = (mm - 1) * nn;
        prev_base = (mm - 2) * nn;
        // the top word's rotated bits wrap into its already shifted low part near the end
        i3  = KIDX_W'((bi >= nn - 3) ? prev_base + 3 : top_base + 3);
        i4  = KIDX_W'((bi >= nn - 4) ? prev_base + 4 : top_base + 4);
        j0  = KIDX_W'(nn);
        j1  = KIDX_W'((bi == nn - 1) ? 1 : nn + 1);
        a3  = ch[i3];
        a4  = ch[i4];
        b0  = (mm == 4) ? ch[j0] : 1'b0;
        b1  = (mm == 4) ? ch[j1] : 1'b0;
        cst = (bi >= 2) ? 1'b1 : ((bi == 0) ? zc : 1'b0);
        fresh = ch[0] ^ a3 ^ a4 ^ b0 ^ b1 ^ cst;
    end

    bitser_fifo #(.SW(SECT_W), .NS(KEY_SECTS)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .load     (load),
        .load_val (key_in),
        .shift    (step),
        .ser_in   (fresh),
        .q        (ch)
    );

    assign kbit = ch[0];

endmodule

// File: rtl/simon_serial_core.sv
module simon_serial_core
    import simon_ser_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   cfg,
    input  logic [31:0]  pt_hi,
    input  logic [31:0]  pt_lo,
    input  logic [127:0] key,
    output logic         busy,
    output logic         done,
    output logic [31:0]  ct_hi,
    output logic [31:0]  ct_lo
);

    cfg_e                  cfg_in, cfg_q, cfg_use;
    logic                  go, last_bit, kbit, zc, wide;
    logic                  t1, t2, t8, fbit, swap;
    logic [BIT_W-1:0]      bit_idx;
    logic [RND_W-1:0]      rnd;
    logic [WMAX-1:0]       xq, yq, x_load, y_load;
    logic [DATA_SECTS-1:0] dmask;
    logic [KEY_SECTS-1:0]  kmask;

    assign cfg_in  = cfg_e'(cfg);
    assign cfg_use = busy ? cfg_q : cfg_in;
    assign dmask   = data_mask(cfg_use);
    assign kmask   = key_mask(cfg_use);
    assign wide    = (cfg_q != CFG_32_64);
    assign zc      = z_bit(cfg_q, rnd);

    simon_ser_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_in   (cfg_in),
        .busy     (busy),
        .done     (done),
        .go       (go),
        .last_bit (last_bit),
        .cfg_q    (cfg_q),
        .bit_idx  (bit_idx),
        .rnd      (rnd)
    );

    simon_ser_keysched u_keys (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_use),
        .act     (kmask),
        .load    (go),
        .key_in  (key),
        .step    (busy),
        .bit_idx (bit_idx),
        .zc      (zc),
        .kbit    (kbit)
    );

    // taps on the recirculating upper word: rotations by 1, 2 and 8
    assign t1   = wide ? xq[31] : xq[15];
    assign t2   = wide ? xq[30] : xq[14];
    assign t8   = wide ? xq[24] : xq[8];
    assign fbit = yq[0] ^ (t1 & t8) ^ t2 ^ kbit;

    // on the last bit of a round the halves trade places
    assign swap   = busy & last_bit;
    assign x_load = go ? pt_hi : push_top(yq, fbit, wide);
    assign y_load = go ? pt_lo : push_top(xq, xq[0], wide);

    bitser_fifo #(.SW(SECT_W), .NS(DATA_SECTS)) u_upper (
        .clk      (clk),
        .rst      (rst),
        .act      (dmask),
        .load     (go | swap),
        .load_val (x_load),
        .shift    (busy),
        .ser_in   (xq[0]),
        .q        (xq)
    );

    bitser_fifo #(.SW(SECT_W), .NS(DATA_SECTS)) u_lower (
        .clk      (clk),
        .rst      (rst),
        .act      (dmask),
        .load     (go | swap),
        .load_val (y_load),
        .shift    (busy),
        .ser_in   (fbit),
        .q        (yq)
    );

    assign ct_hi = xq;
    assign ct_lo = yq;

endmodule

// File: rtl/simon_serial_chk.sv
module simon_serial_chk
    import simon_ser_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  cfg,
    input logic        busy,
    input logic        done,
    input logic [31:0] ct_hi,
    input logic [31:0] ct_lo,
    input cfg_e        cfg_q
);

    logic [RUN_W-1:0] run_cnt;
    logic             accept;

    assign accept = start && !busy && (cfg != 2'd3);

    always_ff @(posedge clk) begin
        if (rst)         run_cnt <= '0;
        else if (accept) run_cnt <= '0;
        else if (busy)   run_cnt <= run_cnt + 1'b1;
    end

    // R4
    done_len_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> run_cnt == RUN_W'(round_total(cfg_q) * word_bits(cfg_q)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (cfg_q == $past(cfg_q)));

    // R6
    bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg == 2'd3) |=> (!busy && !done));

    // R7
    narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q == CFG_32_64) |-> (ct_hi[31:16] == 16'h0 && ct_lo[31:16] == 16'h0));

    // R9
    ct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !accept) |=> ($stable(ct_hi) && $stable(ct_lo)));

endmodule

bind simon_serial_core simon_serial_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .cfg   (cfg),
    .busy  (busy),
    .done  (done),
    .ct_hi (ct_hi),
    .ct_lo (ct_lo),
    .cfg_q (cfg_q)
);

// File: tb/simon_serial_core_bench.sv
module simon_serial_core_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   cfg = 2'd0;
    logic [31:0]  pt_hi = '0;
    logic [31:0]  pt_lo = '0;
    logic [127:0] key = '0;
    logic         busy, done;
    logic [31:0]  ct_hi, ct_lo;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    simon_serial_core u_simon_serial_core (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .cfg   (cfg),
        .pt_hi (pt_hi),
        .pt_lo (pt_lo),
        .key   (key),
        .busy  (busy),
        .done  (done),
        .ct_hi (ct_hi),
        .ct_lo (ct_lo)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] msk_of(int n);
        return (n == 16) ? 32'h0000ffff : 32'hffffffff;
    endfunction

    function automatic logic [31:0] rol(logic [31:0] v, int s, int n);
        return ((v << s) | (v >> (n - s))) & msk_of(n);
    endfunction

    function automatic logic [31:0] ror(logic [31:0] v, int s, int n);
        return ((v >> s) | (v << (n - s))) & msk_of(n);
    endfunction

    function automatic int cyc_of(logic [1:0] c);
        return (c == 2'd0) ? 32 * 16 : ((c == 2'd1) ? 42 * 32 : 44 * 32);
    endfunction

    function automatic string tag_of(logic [1:0] c);
        return (c == 2'd0) ? "R1" : ((c == 2'd1) ? "R2" : "R3");
    endfunction

    function automatic logic [63:0] ref_enc(logic [1:0] c, logic [127:0] kin,
                                            logic [31:0] xh, logic [31:0] yl);
        int n, m, t;
        logic [31:0] mk, x, y, nx, tt, nk;
        logic [31:0] k [4];
        logic [61:0] zz;
        n  = (c == 2'd0) ? 16 : 32;
        m  = (c == 2'd1) ? 3 : 4;
        t  = cyc_of(c) / n;
        mk = msk_of(n);
        if (c == 2'd0)      zz = 62'b11111010001001010110000111001101111101000100101011000011100110;
        else if (c == 2'd1) zz = 62'b10101111011100000011010010011000101000010001111110010110110011;
        else                zz = 62'b11011011101011000110010111100000010010001010011100110100001111;
        for (int j = 0; j < 4; j++) k[j] = (j < m) ? (kin[j*n +: 32] & mk) : 32'h0;
        x = xh & mk;
        y = yl & mk;
        for (int r = 0; r < t; r++) begin
            nx = (rol(x, 1, n) & rol(x, 8, n)) ^ rol(x, 2, n) ^ y ^ k[0];
            y  = x;
            x  = nx;
            tt = ror(k[m-1], 3, n);
            if (m == 4) tt = tt ^ k[1];
            tt = tt ^ ror(tt, 1, n);
            nk = (mk & ~32'h3) ^ {31'h0, zz[61-r]} ^ k[0] ^ tt;
            for (int j = 0; j < 3; j++) if (j < m - 1) k[j] = k[j+1];
            k[m-1] = nk;
        end
        return {x, y};
    endfunction

    task automatic run_op(input logic [1:0] c, input logic [127:0] k, input logic [31:0] xh,
                          input logic [31:0] yl, input int poke,
                          output logic [63:0] res, output int cyc);
        cfg = c; key = k; pt_hi = xh; pt_lo = yl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        chk(busy === 1'b1, "R4 busy after start", {63'h0, busy}, 64'h1);
        while (done !== 1'b1 && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (poke > 0 && cyc == poke) begin
                start = 1'b1; cfg = (c == 2'd0) ? 2'd2 : 2'd0;
                key = ~k; pt_hi = ~xh; pt_lo = ~yl;
            end else begin
                start = 1'b0;
            end
        end
        chk(busy === 1'b0, "R4 busy at done", {63'h0, busy}, 64'h0);
        res = {ct_hi, ct_lo};
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] res, exp, held;
        int cyc;
        logic [1:0] c;
        logic [127:0] k;
        logic [31:0] xh, yl;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8
        chk(busy === 1'b0 && done === 1'b0, "R8 flags", {62'h0, busy, done}, 64'h0);
        chk({ct_hi, ct_lo} === 64'h0, "R8 ciphertext", {ct_hi, ct_lo}, 64'h0);

        // R1 known answer
        run_op(2'd0, 128'h1918111009080100, 32'h6565, 32'h6877, 0, res, cyc);
        chk(res === {32'h0000c69b, 32'h0000e9bb}, "R1 known answer", res, {32'h0000c69b, 32'h0000e9bb});
        chk(cyc == 512, "R4 length 32/64", 64'(cyc), 64'd512);
        // R2 known answer
        run_op(2'd1, 128'h13121110_0b0a0908_03020100, 32'h6f722067, 32'h6e696c63, 0, res, cyc);
        chk(res === 64'h5ca2e27f_111a8fc8, "R2 known answer", res, 64'h5ca2e27f_111a8fc8);
        chk(cyc == 1344, "R4 length 64/96", 64'(cyc), 64'd1344);
        // R3 known answer
        run_op(2'd2, 128'h1b1a1918_13121110_0b0a0908_03020100, 32'h656b696c, 32'h20646e75, 0, res, cyc);
        chk(res === 64'h44c8fc20_b9dfa07a, "R3 known answer", res, 64'h44c8fc20_b9dfa07a);
        chk(cyc == 1408, "R4 length 64/128", 64'(cyc), 64'd1408);

        // random data in all modes, all input bits filled (R7 for unused bits)
        for (int it = 0; it < 12; it++) begin
            c  = 2'(it % 3);
            k  = {$urandom, $urandom, $urandom, $urandom};
            xh = $urandom;
            yl = $urandom;
            run_op(c, k, xh, yl, 0, res, cyc);
            exp = ref_enc(c, k, xh, yl);
            chk(res === exp, tag_of(c), res, exp);
            chk(cyc == cyc_of(c), "R4 length random", 64'(cyc), 64'(cyc_of(c)));
            if (c == 2'd0)
                chk(ct_hi[31:16] === 16'h0 && ct_lo[31:16] === 16'h0, "R7 upper zero",
                    {ct_hi, ct_lo}, {32'h0, 32'h0} | (res & 64'h0000ffff_0000ffff));
        end

        // R7 directed: unused bits set, result must match the masked inputs
        run_op(2'd0, {64'hffffffff_ffffffff, 64'h1918111009080100}, 32'hffff6565, 32'hffff6877, 0, res, cyc);
        chk(res === {32'h0000c69b, 32'h0000e9bb}, "R7 narrow ignores upper bits", res, {32'h0000c69b, 32'h0000e9bb});
        run_op(2'd1, {32'hdeadbeef, 96'h13121110_0b0a0908_03020100}, 32'h6f722067, 32'h6e696c63, 0, res, cyc);
        chk(res === 64'h5ca2e27f_111a8fc8, "R7 96-bit key ignores top word", res, 64'h5ca2e27f_111a8fc8);

        // R5 start while busy
        k = {$urandom, $urandom, $urandom, $urandom};
        xh = $urandom; yl = $urandom;
        run_op(2'd2, k, xh, yl, 300, res, cyc);
        exp = ref_enc(2'd2, k, xh, yl);
        chk(res === exp, "R5 result unchanged by busy start", res, exp);
        chk(cyc == 1408, "R5 length unchanged", 64'(cyc), 64'd1408);
        run_op(2'd0, k, xh, yl, 77, res, cyc);
        exp = ref_enc(2'd0, k, xh, yl);
        chk(res === exp, "R5 narrow run unchanged", res, exp);

        // R6 unused code
        held = {ct_hi, ct_lo};
        cfg = 2'd3; key = ~key; pt_hi = ~pt_hi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b0, "R6 busy stays low", {63'h0, busy}, 64'h0);
        repeat (5) begin
            @(negedge clk);
            chk(done === 1'b0 && busy === 1'b0, "R6 no activity", {62'h0, busy, done}, 64'h0);
        end
        chk({ct_hi, ct_lo} === held, "R6 ciphertext kept", {ct_hi, ct_lo}, held);

        // R9 idle hold
        held = {ct_hi, ct_lo};
        for (int i = 0; i < 10; i++) begin
            cfg = 2'(i % 3); key = {$urandom, $urandom, $urandom, $urandom};
            pt_hi = $urandom; pt_lo = $urandom;
            @(negedge clk);
        end
        chk({ct_hi, ct_lo} === held, "R9 output held while idle", {ct_hi, ct_lo}, held);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule